// File: doc/BRIEF.md
# Four-Mode Capture Timer/Counter

This block is a 2W-bit timer/counter built from two W-bit halves. A two-bit mode picks the arrangement. The halves can run as two independent prescaled timers, or as a prescaled timer in the low half beside an external-event counter in the high half. They can also be cascaded into one wide timer driven by the prescaler, or into one wide counter of external events.

A single programmable prescaler divides the system clock and produces a one-cycle enable. External events pass through a two-flop synchronizer and a rising-edge detector before they count. A rising edge on the capture input copies the live count of both halves into a 2W-bit capture register. In the wide modes that register holds the full cascaded value.

Each half has a match register. When the half reaches its match value it clears to zero and raises a one-cycle flag for the interrupt logic. Configuration uses a small write port. Writing the mode restarts the counters and the prescaler.

Top module: `dual_mode_capture_timer`

## Requirements
- R1: A write with `wr_sel`=0 loads the mode from `wr_data[1:0]`. 0 is two prescaled W-bit timers. 1 is a prescaled timer in the low half and an event counter in the high half. 2 is one prescaled 2W-bit timer. 3 is one 2W-bit event counter.
- R2: A write with `wr_sel`=1 loads the prescaler reload R. Prescaled counters then advance once every R+1 clock cycles.
- R3: In modes 0 and 1, each half is compared with its own match value, written with `wr_sel`=2 for the low half and `wr_sel`=3 for the high half. On an enabled cycle where the count equals the match value, the half clears to zero and its flag (`irq_lo` or `irq_hi`) is high for one cycle. For a prescaled half with match value M, the flag repeats every (R+1)(M+1) cycles.
- R4: In modes 2 and 3, the concatenated count {high,low} is compared with {match_hi,match_lo}. A hit clears both halves and pulses `irq_hi` only. `irq_lo` stays low.
- R5: Each rising edge of `evt_in` advances an event-driven counter by exactly one, provided `evt_in` is held at least two cycles in each level. This applies to the high half in mode 1 and to the wide counter in mode 3. The prescaler has no effect on event-driven counters.
- R6: A rising edge of `cap_in` seen at a clock edge loads `cap_val` with the {high,low} count as it stood before that edge. The value is visible after that edge.
- R7: A mode write clears both counters, the prescaler and both flags. `cap_val` keeps its value.
- R8: Synchronous reset sets mode 0, reload 0, both match values 0, counts 0, `cap_val` 0 and both flags low. With these defaults `irq_lo` is high on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 prescaler reload, 2 low match, 3 high match |
| wr_data | input | W | Write data |
| evt_in | input | 1 | External event input, asynchronous |
| cap_in | input | 1 | Capture strobe, synchronous, rising edge active |
| cap_val | output | 2W | Captured count {high,low} |
| irq_lo | output | 1 | One-cycle match flag of the low half |
| irq_hi | output | 1 | One-cycle match flag of the high half or of the wide counter |

## Verification
The bench builds the block with W=4, so each half spans 16 values and the wide counter spans 256. This keeps every wrap and match within a few hundred cycles. Flag periods are swept over all reloads 0 to 3 against several low and high match values in the split-timer mode, and over a spread of wide match values in mode 2. Each measured period is compared against (R+1)(M+1).

Capture timing is swept across consecutive cycles after a mode write and compared with floor(k/(R+1)). The event modes are driven with counted edges, so that the high flag appears on exactly the (M+1)th edge and the low flag stays silent in the wide modes.

// File: rtl/dual_mode_capture_timer.sv
module dual_mode_capture_timer #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [W-1:0]   wr_data,
  input  logic           evt_in,
  input  logic           cap_in,
  output logic [2*W-1:0] cap_val,
  output logic           irq_lo,
  output logic           irq_hi
);

  logic [1:0]   mode;
  logic [W-1:0] reload, match_lo, match_hi;
  logic [W-1:0] pcnt, cnt_lo, cnt_hi;
  logic [2:0]   evt_sync;
  logic         cap_q;

  wire mode_wr   = wr_en && (wr_sel == 2'd0);
  wire tick      = (pcnt >= reload);
  wire evt_pulse = evt_sync[1] & ~evt_sync[2];
  wire cap_rise  = cap_in & ~cap_q;
  wire wide      = mode[1];
  wire en_lo     = (mode == 2'd3) ? evt_pulse : tick;
  wire en_hi     = (mode == 2'd1) ? evt_pulse : tick;
  wire en_wide   = mode[0] ? evt_pulse : tick;

  wire [2*W-1:0] cnt_wide = {cnt_hi, cnt_lo};
  wire hit_lo   = (cnt_lo == match_lo);
  wire hit_hi   = (cnt_hi == match_hi);
  wire hit_wide = (cnt_wide == {match_hi, match_lo});

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= 2'd0;
      reload   <= '0;
      match_lo <= '0;
      match_hi <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: mode     <= wr_data[1:0];
        2'd1: reload   <= wr_data;
        2'd2: match_lo <= wr_data;
        default: match_hi <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_sync <= '0;
      cap_q    <= 1'b0;
    end else begin
      evt_sync <= {evt_sync[1:0], evt_in};
      cap_q    <= cap_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      pcnt   <= '0;
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      pcnt   <= tick ? '0 : pcnt + 1'b1;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      if (wide) begin
        if (en_wide) begin
          if (hit_wide) begin
            {cnt_hi, cnt_lo} <= '0;
            irq_hi <= 1'b1;
          end else begin
            {cnt_hi, cnt_lo} <= cnt_wide + 1'b1;
          end
        end
      end else begin
        if (en_lo) begin
          if (hit_lo) begin
            cnt_lo <= '0;
            irq_lo <= 1'b1;
          end else begin
            cnt_lo <= cnt_lo + 1'b1;
          end
        end
        if (en_hi) begin
          if (hit_hi) begin
            cnt_hi <= '0;
            irq_hi <= 1'b1;
          end else begin
            cnt_hi <= cnt_hi + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cap_val <= '0;
    else if (cap_rise) cap_val <= cnt_wide;
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cnt_wide == '0 && pcnt == '0 && !irq_lo && !irq_hi)); // R7
  AST_IRQ_HI_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> (wide ? (cnt_wide == '0) : (cnt_hi == '0))); // R3
  AST_WIDE_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
    wide |-> !irq_lo); // R4
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |=> !evt_pulse); // R5
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (rst)
    cap_rise |=> (cap_val == $past(cnt_wide))); // R6

endmodule

// File: tb/test_dual_mode_capture_timer.sv
`timescale 1ns/1ps
module test_dual_mode_capture_timer;
  localparam int W = 4;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, evt_in = 1'b0, cap_in = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [2*W-1:0] cap_val;
  logic irq_lo, irq_hi;
  int checks = 0, errors = 0, lo_cnt = 0, hi_cnt = 0;

  dual_mode_capture_timer #(.W(W)) i_dual_mode_capture_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_in(evt_in), .cap_in(cap_in), .cap_val(cap_val),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (irq_lo) lo_cnt++;
    if (irq_hi) hi_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int md, input int r, input int ml, input int mh);
    wr(2'd1, r); wr(2'd2, ml); wr(2'd3, mh); wr(2'd0, md);
    lo_cnt = 0; hi_cnt = 0;
  endtask

  task automatic measure(input bit hi, output int per);
    int n = 0;
    while (!(hi ? irq_hi : irq_lo) && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    n = 1;
    while (!(hi ? irq_hi : irq_lo) && n < 2000) begin @(negedge clk); n++; end
    per = n;
  endtask

  task automatic capture_after(input int k);
    repeat (k) @(negedge clk);
    cap_in = 1'b1;
    @(negedge clk);
    cap_in = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    evt_in = 1'b1;
    repeat (2) @(negedge clk);
    evt_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, exp;
    repeat (3) @(negedge clk);
    chk(cap_val == 0, "R8 cap_val in reset", cap_val, 0);
    chk(!irq_lo && !irq_hi, "R8 flags in reset", {irq_hi, irq_lo}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq_lo == 1'b1, "R8 default flag every cycle", irq_lo, 1);
    measure(1'b0, per);
    chk(per == 1, "R8 default period", per, 1);

    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++) begin
        setup(0, r, m, m + 3);
        measure(1'b0, per); exp = (r + 1) * (m + 1);
        chk(per == exp, "R2 R3 mode0 low period", per, exp);
        measure(1'b1, per); exp = (r + 1) * (m + 4);
        chk(per == exp, "R1 R3 mode0 high period", per, exp);
      end

    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 4; i++) begin
        int mw = (i == 0) ? 0 : (i == 1) ? 5 : (i == 2) ? 17 : 40;
        setup(2, r, mw & 15, mw >> 4);
        measure(1'b1, per); exp = (r + 1) * (mw + 1);
        chk(per == exp, "R4 mode2 wide period", per, exp);
        chk(lo_cnt == 0, "R4 low flag quiet in mode2", lo_cnt, 0);
      end

    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 12; k++) begin
        setup(2, r, 15, 15);
        capture_after(k); exp = k / (r + 1);
        chk(cap_val == exp, "R6 R7 mode2 capture", cap_val, exp);
      end

    for (int k = 0; k < 10; k++) begin
      setup(0, 1, 15, 15);
      capture_after(k); exp = ((k / 2) << 4) | (k / 2);
      chk(cap_val == exp, "R6 mode0 split capture", cap_val, exp);
    end

    exp = cap_val;
    wr(2'd0, 2);
    repeat (3) @(negedge clk);
    chk(cap_val == exp, "R7 capture kept over mode write", cap_val, exp);

    for (int m = 0; m < 4; m++) begin
      setup(1, 0, 15, m);
      for (int e = 0; e < m; e++) pulse_evt();
      chk(hi_cnt == 0, "R5 mode1 no high flag before match", hi_cnt, 0);
      pulse_evt();
      chk(hi_cnt == 1, "R3 R5 mode1 high flag on match event", hi_cnt, 1);
    end

    setup(1, 2, 1, 15);
    measure(1'b0, per);
    chk(per == 6, "R1 mode1 low half prescaled", per, 6);

    for (int n = 0; n < 6; n++) begin
      setup(3, 0, 15, 15);
      for (int e = 0; e < n; e++) pulse_evt();
      capture_after(2);
      chk(cap_val == n, "R5 mode3 event count capture", cap_val, n);
    end

    for (int mw = 3; mw < 20; mw += 16) begin
      setup(3, 0, mw & 15, mw >> 4);
      for (int e = 0; e < mw; e++) pulse_evt();
      chk(hi_cnt == 0, "R4 mode3 no flag before match", hi_cnt, 0);
      pulse_evt();
      chk(hi_cnt == 1, "R4 mode3 flag on match", hi_cnt, 1);
      chk(lo_cnt == 0, "R4 mode3 low flag quiet", lo_cnt, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule